// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a serial memory that sits on a two-wire bus made of a clock line and a data line. Both lines are sampled on a faster system clock. The block finds the bus conditions that open and close a transaction. It shifts bytes in and out most significant bit first and decides, byte by byte, whether to acknowledge. The first byte after an opening condition selects the device and the direction. A write then carries two address bytes, which load a 13-bit pointer, followed by data bytes. A read streams bytes from the pointer onward.

On the memory side, write bytes leave on a valid/ready stream and read data is fetched through a valid/ready request plus a one-beat response. A write beat is held, with address and data stable, until `wr_ready` is seen high. If the next data byte completes while that beat is still waiting, the byte is refused with a NACK and dropped, so back-pressure reaches the bus master as a refusal. The request stream `rd_req_valid`/`rd_req_ready` follows the same hold rule. The response `rd_rsp_valid` has no ready signal: the memory must answer before the next falling edge of the bus clock. A closing condition after accepted write bytes raises a one-cycle commit strobe. The memory side holds `busy` high for its whole programming cycle.

The data line is open-drain. `sda_oe` high pulls the line low. The block never drives a one.

Top module: `twowire_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high opens a transaction, and a rising data line while the clock is high closes it. An opening condition in the middle of a byte discards the partial byte and restarts decoding at the control byte.
- R2: The control byte is acknowledged only when its upper four bits are 1010 and bits 3..1 equal `strap_sel`. Bit 0 selects read (1) or write (0). On a mismatch, that byte and every later byte up to the next opening condition are left unacknowledged.
- R3: After a write control byte, the high address byte is acknowledged only if its top three bits are zero. Its low five bits become pointer bits 12..8. A nonzero top field gets a NACK and the transaction is ignored.
- R4: Each acknowledged write data byte is emitted as `wr_data` with `wr_addr` equal to the pointer. Afterwards only pointer bits 5..0 increment, wrapping inside the 64-byte line while bits 12..6 stay fixed.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. A data byte that completes while a beat is still pending is NACKed and dropped, and the pointer does not advance.
- R6: `wr_commit` is a one-cycle pulse on a closing condition, given only if the transaction acknowledged at least one write data byte.
- R7: While `busy` is high, no byte of any kind is acknowledged.
- R8: A read control byte issues a request at the pointer. Each accepted request advances the full 13-bit pointer, wrapping from 0x1FFF to 0x0000. Returned bytes are sent MSB first.
- R9: When the master leaves the acknowledge bit of a read byte high, the block releases the data line, issues no further request and stays off the bus until the next opening condition.
- R10: `sda_oe` rises only while the clock line is low. An acknowledge holds the line low for the whole ninth clock.
- R11: After reset, `sda_oe`, `wr_valid`, `rd_req_valid` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel | input | 3 | Pin-strapped device select |
| busy | input | 1 | Memory programming cycle in progress |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts write beat |
| wr_addr | output | 13 | Write byte address |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Start programming, one cycle |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_addr | output | 13 | Read request address |
| rd_rsp_valid | input | 1 | Read data valid, one cycle |
| rd_rsp_data | input | 8 | Read data |

## Verification
Each line passes through two sync flops and one edge register, so a bus edge acts about three system cycles after it happens on the wire. Acknowledge and transmit bits therefore appear during the low phase that follows a falling clock edge. The bench holds each bus half-period for eight cycles and samples the data line halfway through the high phase, long after the block has settled. Memory-side outputs are compared a few cycles after the byte or condition that produced them, never at the edge itself.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA, ST_SKIP
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 13,
  parameter int         PAGE_W      = 6,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_sel,
  input  logic              busy,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data
);
  import tw_pkg::*;

  localparam int HI_BITS = ADDR_W - 8;

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  tw_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c));

  tw_state_e         state;
  logic [3:0]        bit_cnt;
  logic [7:0]        sh;
  logic [6:0]        tx_sh;
  logic [7:0]        tx_byte;
  logic [ADDR_W-1:0] ptr;
  logic              in_ack, rd_first, mack, wrote;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      sh           <= '0;
      tx_sh        <= '0;
      tx_byte      <= '0;
      ptr          <= '0;
      in_ack       <= 1'b0;
      rd_first     <= 1'b0;
      mack         <= 1'b0;
      wrote        <= 1'b0;
      sda_oe       <= 1'b0;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      wr_commit    <= 1'b0;
      rd_req_valid <= 1'b0;
    end else begin
      wr_commit <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        rd_req_valid <= 1'b0;
        ptr          <= ptr + ADDR_W'(1);
      end
      if (rd_rsp_valid) tx_byte <= rd_rsp_data;

      if (start_c) begin
        state    <= ST_CTRL;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        rd_first <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        if (wrote) wr_commit <= 1'b1;
        wrote  <= 1'b0;
      end else if (state != ST_IDLE && state != ST_SKIP) begin
        if (scl_rise) begin
          bit_cnt <= (bit_cnt == 4'd8) ? 4'd0 : bit_cnt + 4'd1;
          if (bit_cnt < 4'd8 && state != ST_RDATA) sh <= {sh[6:0], sda_s};
          if (in_ack && state == ST_RDATA && !rd_first) begin
            mack <= ~sda_s;
            if (!sda_s) rd_req_valid <= 1'b1;
          end
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack   <= 1'b0;
            rd_first <= 1'b0;
            if (state == ST_RDATA && (rd_first || mack)) begin
              tx_sh  <= tx_byte[6:0];
              sda_oe <= ~tx_byte[7];
            end else begin
              sda_oe <= 1'b0;
              if (state == ST_RDATA) state <= ST_SKIP;
            end
          end else if (bit_cnt == 4'd8) begin
            in_ack <= 1'b1;
            sda_oe <= 1'b0;
            unique case (state)
              ST_CTRL: begin
                if (sh[7:4] == DEV_CODE && sh[3:1] == strap_sel && !busy) begin
                  sda_oe <= 1'b1;
                  if (sh[0]) begin
                    state        <= ST_RDATA;
                    rd_first     <= 1'b1;
                    rd_req_valid <= 1'b1;
                  end else begin
                    state <= ST_AHI;
                  end
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_AHI: begin
                if (!busy && sh[7:HI_BITS] == '0) begin
                  sda_oe            <= 1'b1;
                  ptr[ADDR_W-1:8]   <= sh[HI_BITS-1:0];
                  state             <= ST_ALO;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_ALO: begin
                if (!busy) begin
                  sda_oe    <= 1'b1;
                  ptr[7:0]  <= sh;
                  state     <= ST_WDATA;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_WDATA: begin
                if (!busy && !(wr_valid && !wr_ready)) begin
                  sda_oe              <= 1'b1;
                  wr_valid            <= 1'b1;
                  wr_addr             <= ptr;
                  wr_data             <= sh;
                  ptr[PAGE_W-1:0]     <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                  wrote               <= 1'b1;
                end
              end
              default: ;
            endcase
          end else if (state == ST_RDATA) begin
            sda_oe <= ~tx_sh[6];
            tx_sh  <= {tx_sh[5:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/tw_slave_checker.sv
module tw_slave_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              busy,
  input logic              sda_oe,
  input logic              in_ack,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_commit,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr
);
  // R10: the pull-down only engages while the clock line is low
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  // R7: an acknowledge slot opened while busy never pulls the line
  a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $rose(in_ack)) |-> !sda_oe);

  // R5: a stalled write beat keeps its content
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8: a stalled read request keeps its address
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R6: the commit strobe lasts one cycle
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

bind twowire_mem_slave tw_slave_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .busy(busy), .sda_oe(sda_oe),
  .in_ack(in_ack), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr));

// File: tb/test_twowire_mem_slave.sv
module test_twowire_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic wr_valid, wr_ready, wr_commit, rd_req_valid, rd_req_ready;
  logic [12:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic rd_rsp_valid = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;

  int checks = 0, fails = 0, cyc = 0;
  int wr_n = 0, req_n = 0, commit_n = 0, bad_oe = 0;
  logic [12:0] log_addr [32];
  logic [7:0]  log_data [32];
  logic [12:0] req_log  [32];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rd_req_ready = 1'b1;

  twowire_mem_slave i_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .strap_sel(STRAP), .busy(busy),
    .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data));

  function automatic logic [7:0] memval(input logic [12:0] a);
    return (a[7:0] ^ a[12:5]) + 8'h3C;
  endfunction

  logic oe_q = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    oe_q <= sda_oe;
    if (sda_oe && !oe_q && scl) bad_oe <= bad_oe + 1;
    if (wr_valid && wr_ready) begin
      log_addr[wr_n[4:0]] <= wr_addr;
      log_data[wr_n[4:0]] <= wr_data;
      wr_n <= wr_n + 1;
    end
    if (rd_req_valid) begin
      req_log[req_n[4:0]] <= rd_addr;
      req_n <= req_n + 1;
    end
    rd_rsp_valid <= rd_req_valid;
    rd_rsp_data  <= memval(rd_addr);
    if (wr_commit) commit_n <= commit_n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF); scl = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF); scl = 1'b0; wt(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF); scl = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; wt(HALF); scl = 1'b1; wt(HALF/2);
    seen = sda_line; wt(HALF/2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic t_reset();
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 wr_valid", wr_valid, 0);
    chk("R11 rd_req_valid", rd_req_valid, 0);
    chk("R11 wr_commit", wr_commit, 0);
  endtask

  task automatic t_byte_write();
    logic a; int n0 = wr_n, c0 = commit_n;
    bus_start();
    send_byte(CW, a);     chk("R2 ctrl ack", a, 1);
    send_byte(8'h12, a);  chk("R3 hi ack", a, 1);
    send_byte(8'h34, a);  chk("R10 lo ack", a, 1);
    send_byte(8'h5A, a);  chk("R4 data ack", a, 1);
    wt(4);
    chk("R4 write count", wr_n - n0, 1);
    chk("R4 write addr", log_addr[n0[4:0]], 13'h1234);
    chk("R4 write data", log_data[n0[4:0]], 8'h5A);
    bus_stop(); wt(4);
    chk("R6 commit once", commit_n - c0, 1);
  endtask

  task automatic t_wrong_device();
    logic a; int n0 = wr_n;
    bus_start();
    send_byte({4'b1010, 3'b000, 1'b0}, a); chk("R2 select mismatch nack", a, 0);
    send_byte(8'h00, a);                   chk("R2 later byte nack", a, 0);
    bus_stop(); bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, a);  chk("R2 code mismatch nack", a, 0);
    bus_stop(); wt(4);
    chk("R2 no write", wr_n - n0, 0);
  endtask

  task automatic t_bad_high();
    logic a;
    bus_start();
    send_byte(CW, a);
    send_byte(8'h20, a); chk("R3 high field nack", a, 0);
    send_byte(8'h00, a); chk("R3 ignored after", a, 0);
    bus_stop();
  endtask

  task automatic t_page_wrap();
    logic a; int n0 = wr_n;
    bus_start();
    send_byte(CW, a); send_byte(8'h1F, a); send_byte(8'h7E, a);
    send_byte(8'hA1, a); send_byte(8'hA2, a); send_byte(8'hA3, a);
    wt(4); bus_stop(); wt(4);
    chk("R4 wrap count", wr_n - n0, 3);
    chk("R4 addr0", log_addr[n0[4:0]], 13'h1F7E);
    chk("R4 addr1", log_addr[5'(n0+1)], 13'h1F7F);
    chk("R4 addr wrap", log_addr[5'(n0+2)], 13'h1F40);
    chk("R4 data wrap", log_data[5'(n0+2)], 8'hA3);
  endtask

  task automatic t_busy();
    logic a; int c0 = commit_n;
    busy = 1'b1;
    bus_start();
    send_byte(CW, a); chk("R7 busy ctrl nack", a, 0);
    bus_stop(); bus_start();
    send_byte(CR, a); chk("R7 busy read nack", a, 0);
    bus_stop(); wt(4);
    chk("R7 no commit", commit_n - c0, 0);
    busy = 1'b0;
  endtask

  task automatic t_backpressure();
    logic a; int n0 = wr_n;
    wr_ready = 1'b0;
    bus_start();
    send_byte(CW, a); send_byte(8'h01, a); send_byte(8'h00, a);
    send_byte(8'h11, a); chk("R5 first ack", a, 1);
    send_byte(8'h22, a); chk("R5 stalled nack", a, 0);
    chk("R5 held valid", wr_valid, 1);
    chk("R5 held data", wr_data, 8'h11);
    chk("R5 held addr", wr_addr, 13'h0100);
    wr_ready = 1'b1; wt(3);
    chk("R5 drained", wr_n - n0, 1);
    send_byte(8'h33, a); chk("R5 resumes ack", a, 1);
    wt(4);
    chk("R5 pointer not advanced by drop", log_addr[5'(n0+1)], 13'h0101);
    bus_stop(); wt(4);
  endtask

  task automatic t_no_commit();
    logic a; int c0 = commit_n;
    bus_start();
    send_byte(CW, a); send_byte(8'h00, a); send_byte(8'h10, a);
    bus_stop(); wt(4);
    chk("R6 no data no commit", commit_n - c0, 0);
  endtask

  task automatic t_read();
    logic a; logic [7:0] b; int r0 = req_n;
    bus_start();
    send_byte(CW, a); send_byte(8'h1F, a); send_byte(8'hFF, a);
    bus_start();
    send_byte(CR, a); chk("R8 read ctrl ack", a, 1);
    recv_byte(1'b1, b); chk("R8 byte at 1FFF", b, memval(13'h1FFF));
    recv_byte(1'b0, b); chk("R8 byte after wrap", b, memval(13'h0000));
    wt(HALF);
    chk("R8 wrapped request addr", req_log[5'(r0+1)], 13'h0000);
    chk("R9 released", sda_oe, 0);
    chk("R9 no extra request", req_n - r0, 2);
    for (int i = 0; i < 8; i++) begin
      logic s; bus_bit(1'b1, s);
      chk("R9 line stays high", s, 1);
    end
    bus_stop(); wt(4);
    chk("R9 request count", req_n - r0, 2);
  endtask

  task automatic t_restart_mid();
    logic a; logic s;
    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    bus_start();
    send_byte(CW, a); chk("R1 restart decodes ctrl", a, 1);
    bus_stop(); wt(4);
    chk("R1 idle after stop", sda_oe, 0);
  endtask

  initial begin
    wr_ready = 1'b1;
    wt(5);
    t_reset();
    rst_n = 1'b1;
    wt(5);
    t_byte_write();
    t_wrong_device();
    t_bad_high();
    t_page_wrap();
    t_busy();
    t_backpressure();
    t_no_commit();
    t_read();
    t_restart_mid();
    chk("R10 oe never rose with scl high", bad_oe, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule